// File: doc/BRIEF.md
# Power-Management Register Slave on I2C

This block is a two-wire serial slave that sits beside a power controller and lets a host processor switch supply domains. It answers only at the 8-bit device byte 0x7A (write) / 0x7B (read). It holds a pointer and a small register file. Level outputs come from the register file: one supply enable for an MMC card bus and one for each of two cameras. A one-clock power-cycle pulse is raised when two reset registers are written in a fixed order.

Each transaction follows the common pointer-then-data pattern. The first byte after the device byte loads the register pointer. Further written bytes are stored at the pointer, which advances after each one. A repeated start with the read device byte returns register contents, most significant bit first, and the pointer again advances per byte. The bus lines are brought into the system clock domain through flop synchronisers before any edge is detected. The slave pulls SDA low through an open-drain enable.

Top module: `pwr_i2c_ctrl`

## Requirements
- R1: After reset the MMC supply enable is 1, both camera enables are 0, the power-cycle output is 0 and SDA is not driven.
- R2: A device byte of 0x7A (write) or 0x7B (read) is acknowledged by pulling SDA low during the ninth clock.
- R3: Any other device byte gets no acknowledge, and the data bytes that follow it change no register and no output.
- R4: In a write, the first byte after the device byte loads the pointer. Each later byte is stored at the pointer, and the pointer then increments by one.
- R5: A read returns the stored value at the pointer, MSB first, then increments the pointer. Bytes continue while the master acknowledges. Unimplemented addresses read 0.
- R6: The MMC supply enable is the inverse of bit 0 of register 0x12. Writing 1 turns the supply off and writing 0 turns it on.
- R7: Register 0x31 selects camera power. Value 1 enables camera 0 only, value 2 enables camera 1 only, and 0 or any other value enables neither.
- R8: Writing 0x01 to register 0x70 and then, as the very next register write, 0x01 to register 0x11 raises the power-cycle output for exactly one clock.
- R9: Writing 0x01 to 0x11 when no arming write to 0x70 came directly before it produces no power-cycle pulse. Any other register write in between also cancels the arming.
- R10: In the clock where the power-cycle pulse is high, all four registers hold 0. The MMC supply is therefore on and both cameras are off, and reads of 0x70, 0x11, 0x12 and 0x31 return 0.
- R11: Every byte written to a matched slave is acknowledged, and SDA is released once a stop condition is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| mmc_pwr_en | output | 1 | MMC card bus supply enable |
| cam0_pwr_en | output | 1 | Camera 0 supply enable |
| cam1_pwr_en | output | 1 | Camera 1 supply enable |
| pwr_cycle | output | 1 | One-clock power-cycle request |

## Verification
The write of 0x01 to register 0x11 that completes an armed sequence commits the byte and clears the whole register file in the same clock. That write must not survive the clear. To provoke this, the bench first turns the MMC supply off and selects a camera. It then arms with 0x70 and finishes with 0x11. The judgement is that the pulse count rises by exactly one, the pulse is never two clocks wide, and the supplies return to their reset levels. Read-back of 0x70, 0x11 and 0x12 must then give 0 rather than the value just written.

// File: rtl/pwr_i2c_pkg.sv
package pwr_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } fe_state_t;

    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  REG_RST1  = 8'h70;
    localparam logic [7:0]  REG_RST2  = 8'h11;
    localparam logic [7:0]  REG_MMC   = 8'h12;
    localparam logic [7:0]  REG_CAM   = 8'h31;
    localparam logic [7:0]  ARM_VALUE = 8'h01;

endpackage

// File: rtl/pwr_i2c_sync.sv
module pwr_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;
    logic  scl_now;

    assign scl_now = q.scl_pipe[STAGES-1];
    assign sda_s   = q.sda_pipe[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_in};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_in};
        d.scl_prev = scl_now;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_rise  = scl_now & ~q.scl_prev;
    assign scl_fall  = ~scl_now & q.scl_prev;
    assign start_det = scl_now & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_now & q.scl_prev & ~q.sda_prev & sda_s;

endmodule

// File: rtl/pwr_i2c_frontend.sv
module pwr_i2c_frontend
    import pwr_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              byte_stb,
    output logic              byte_is_ptr,
    output logic [BYTE_W-1:0] byte_val,
    output logic              rd_adv
);

    localparam logic [3:0] BITS_FULL = 4'(BYTE_W);
    localparam logic [3:0] BITS_LAST = 4'(BYTE_W - 1);

    typedef struct packed {
        fe_state_t         st;
        logic [BYTE_W-1:0] sh;
        logic [3:0]        cnt;
        logic              rw;
        logic              first;
        logic              nack;
        logic              stb;
        logic              is_ptr;
        logic              adv;
    } fe_t;

    fe_t q, d;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        d.adv = 1'b0;
        if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
        end else begin
            case (q.st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS_FULL) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.st    = ST_ADDR_ACK;
                                d.rw    = q.sh[0];
                                d.first = 1'b1;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st     = ST_WR_ACK;
                            d.stb    = 1'b1;
                            d.is_ptr = q.first;
                            d.first  = 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = ST_RD;
                            d.sh = rd_data;
                        end else begin
                            d.st = ST_WR;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.st  = ST_WR;
                        d.cnt = '0;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (q.cnt == BITS_LAST) begin
                            d.st  = ST_RD_ACK;
                            d.adv = 1'b1;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) d.nack = sda_s;
                    if (scl_fall) begin
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st  = ST_RD;
                            d.sh  = rd_data;
                            d.cnt = '0;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        case (q.st)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:                  sda_oe = ~q.sh[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

    assign byte_stb    = q.stb;
    assign byte_is_ptr = q.is_ptr;
    assign byte_val    = q.sh;
    assign rd_adv      = q.adv;

    // R11: a stop always lets go of the data line on the next clock
    p_release_on_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> !sda_oe);

endmodule

// File: rtl/pwr_i2c_regs.sv
module pwr_i2c_regs
    import pwr_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              wr_is_ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_adv,
    output logic [BYTE_W-1:0] rd_data,
    output logic              mmc_pwr_en,
    output logic              cam0_pwr_en,
    output logic              cam1_pwr_en,
    output logic              pwr_cycle
);

    typedef struct packed {
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] rst1;
        logic [BYTE_W-1:0] rst2;
        logic [BYTE_W-1:0] mmc;
        logic [BYTE_W-1:0] cam;
        logic              armed;
        logic              pulse;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (wr_stb) begin
            if (wr_is_ptr) begin
                d.ptr = wr_data;
            end else begin
                d.ptr = q.ptr + 1'b1;
                case (q.ptr)
                    REG_RST1: d.rst1 = wr_data;
                    REG_RST2: d.rst2 = wr_data;
                    REG_MMC:  d.mmc  = wr_data;
                    REG_CAM:  d.cam  = wr_data;
                    default:  ;
                endcase
                if (q.ptr == REG_RST1 && wr_data == ARM_VALUE) begin
                    d.armed = 1'b1;
                end else if (q.ptr == REG_RST2 && wr_data == ARM_VALUE && q.armed) begin
                    d.pulse = 1'b1;
                    d.armed = 1'b0;
                    d.rst1  = '0;
                    d.rst2  = '0;
                    d.mmc   = '0;
                    d.cam   = '0;
                end else begin
                    d.armed = 1'b0;
                end
            end
        end else if (rd_adv) begin
            d.ptr = q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.ptr)
            REG_RST1: rd_data = q.rst1;
            REG_RST2: rd_data = q.rst2;
            REG_MMC:  rd_data = q.mmc;
            REG_CAM:  rd_data = q.cam;
            default:  rd_data = '0;
        endcase
    end

    assign mmc_pwr_en  = ~q.mmc[0];
    assign cam0_pwr_en = (q.cam == 8'd1);
    assign cam1_pwr_en = (q.cam == 8'd2);
    assign pwr_cycle   = q.pulse;

    // R8: the request never lasts longer than one clock
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle |=> !pwr_cycle);

    // R9: a request is only possible from the armed state
    p_pulse_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle |-> $past(q.armed));

    // R10: supplies are at reset levels while the request is high
    p_wipe_on_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle |-> (mmc_pwr_en && !cam0_pwr_en && !cam1_pwr_en && !q.armed));

endmodule

// File: rtl/pwr_i2c_ctrl.sv
module pwr_i2c_ctrl
    import pwr_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3D,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    output logic mmc_pwr_en,
    output logic cam0_pwr_en,
    output logic cam1_pwr_en,
    output logic pwr_cycle
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              byte_stb;
    logic              byte_is_ptr;
    logic [BYTE_W-1:0] byte_val;
    logic              rd_adv;
    logic [BYTE_W-1:0] rd_data;

    pwr_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    pwr_i2c_frontend #(.DEV_ADDR(DEV_ADDR)) u_fe (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .rd_data     (rd_data),
        .sda_oe      (sda_oe),
        .byte_stb    (byte_stb),
        .byte_is_ptr (byte_is_ptr),
        .byte_val    (byte_val),
        .rd_adv      (rd_adv)
    );

    pwr_i2c_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (byte_stb),
        .wr_is_ptr   (byte_is_ptr),
        .wr_data     (byte_val),
        .rd_adv      (rd_adv),
        .rd_data     (rd_data),
        .mmc_pwr_en  (mmc_pwr_en),
        .cam0_pwr_en (cam0_pwr_en),
        .cam1_pwr_en (cam1_pwr_en),
        .pwr_cycle   (pwr_cycle)
    );

endmodule

// File: tb/pwr_i2c_ctrl_test.sv
module pwr_i2c_ctrl_test;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe, mmc_pwr_en, cam0_pwr_en, cam1_pwr_en, pwr_cycle;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int wide_pulses = 0;
    logic prev_pulse = 1'b0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] rx_byte;
    string      rx_req;
    event       rx_ev;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    pwr_i2c_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_bus),
        .sda_oe      (sda_oe),
        .mmc_pwr_en  (mmc_pwr_en),
        .cam0_pwr_en (cam0_pwr_en),
        .cam1_pwr_en (cam1_pwr_en),
        .pwr_cycle   (pwr_cycle)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (pwr_cycle) pulses++;
        if (pwr_cycle && prev_pulse) wide_pulses++;
        prev_pulse <= pwr_cycle;
    end

    // scoreboard monitor: pops the expected byte for every byte read back
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, rx_req, rx_byte, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_byte == e, rx_req, rx_byte, e);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = ~sda_bus;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic rbyte(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
            b[i] = sda_bus;
            wq(); scl_m = 1'b0; wq();
        end
        sda_m = nack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic wr1(input logic [7:0] ptr, input logic [7:0] data);
        bit a;
        bus_start();
        wbyte(8'h7A, a); chk(a, "R2 write addr ack", a, 1);
        wbyte(ptr, a);   chk(a, "R11 ptr ack", a, 1);
        wbyte(data, a);  chk(a, "R11 data ack", a, 1);
        bus_stop();
        chk(!sda_oe, "R11 release after stop", sda_oe, 0);
    endtask

    task automatic wr2(input logic [7:0] ptr, input logic [7:0] d0, input logic [7:0] d1);
        bit a;
        bus_start();
        wbyte(8'h7A, a); chk(a, "R2 write addr ack", a, 1);
        wbyte(ptr, a);   chk(a, "R11 ptr ack", a, 1);
        wbyte(d0, a);    chk(a, "R11 data0 ack", a, 1);
        wbyte(d1, a);    chk(a, "R4 data1 ack", a, 1);
        bus_stop();
    endtask

    task automatic rd_burst(input logic [7:0] ptr, input int n, input string req);
        bit a;
        logic [7:0] b;
        bus_start();
        wbyte(8'h7A, a); chk(a, "R2 addr ack", a, 1);
        wbyte(ptr, a);   chk(a, "R11 ptr ack", a, 1);
        scl_m = 1'b0; bus_start();
        wbyte(8'h7B, a); chk(a, "R2 read addr ack", a, 1);
        for (int k = 0; k < n; k++) begin
            rbyte(k == n - 1, b);
            rx_byte = b;
            rx_req  = req;
            ->rx_ev;
            @(negedge clk);
        end
        bus_stop();
        chk(!sda_oe, "R11 release after read", sda_oe, 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        bit a;
        repeat (10) @(negedge clk);
        // R1 reset state
        chk(mmc_pwr_en == 1'b1, "R1 mmc on", mmc_pwr_en, 1);
        chk(!cam0_pwr_en && !cam1_pwr_en, "R1 cams off", {cam1_pwr_en, cam0_pwr_en}, 0);
        chk(!pwr_cycle, "R1 no pulse", pwr_cycle, 0);
        chk(!sda_oe, "R1 sda released", sda_oe, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R6 MMC supply control
        wr1(8'h12, 8'h01);
        chk(mmc_pwr_en == 1'b0, "R6 mmc off", mmc_pwr_en, 0);
        wr1(8'h12, 8'h00);
        chk(mmc_pwr_en == 1'b1, "R6 mmc on", mmc_pwr_en, 1);

        // R7 camera select
        wr1(8'h31, 8'h01);
        chk({cam1_pwr_en, cam0_pwr_en} == 2'b01, "R7 cam0", {cam1_pwr_en, cam0_pwr_en}, 1);
        wr1(8'h31, 8'h03);
        chk({cam1_pwr_en, cam0_pwr_en} == 2'b00, "R7 value3", {cam1_pwr_en, cam0_pwr_en}, 0);
        wr1(8'h31, 8'h00);
        chk({cam1_pwr_en, cam0_pwr_en} == 2'b00, "R7 off", {cam1_pwr_en, cam0_pwr_en}, 0);
        wr1(8'h31, 8'h02);
        chk({cam1_pwr_en, cam0_pwr_en} == 2'b10, "R7 cam1", {cam1_pwr_en, cam0_pwr_en}, 2);

        // R4 burst write: 0x11 <- 0, 0x12 <- 1
        wr2(8'h11, 8'h00, 8'h01);
        chk(mmc_pwr_en == 1'b0, "R4 auto-increment into 0x12", mmc_pwr_en, 0);

        // R5 read back with increment and unimplemented zeros
        exp_q.push_back(8'h00); exp_q.push_back(8'h01);
        rd_burst(8'h11, 2, "R5 read 0x11..0x12");
        exp_q.push_back(8'h00); exp_q.push_back(8'h02); exp_q.push_back(8'h00);
        rd_burst(8'h30, 3, "R5 read 0x30..0x32");

        // R3 foreign address ignored
        bus_start();
        wbyte(8'h78, a); chk(!a, "R3 no ack foreign addr", a, 0);
        wbyte(8'h12, a);
        wbyte(8'h00, a);
        bus_stop();
        chk(mmc_pwr_en == 1'b0, "R3 mmc unchanged", mmc_pwr_en, 0);
        exp_q.push_back(8'h01);
        rd_burst(8'h12, 1, "R3 reg 0x12 unchanged");

        // R9 cancelled sequences
        wr1(8'h31, 8'h01);
        wr1(8'h11, 8'h01);
        chk(pulses == 0, "R9 no pulse without arm", pulses, 0);
        wr1(8'h70, 8'h01);
        wr1(8'h31, 8'h01);
        wr1(8'h11, 8'h01);
        chk(pulses == 0, "R9 no pulse after intervening write", pulses, 0);
        chk(cam0_pwr_en == 1'b1, "R9 state kept", cam0_pwr_en, 1);

        // R8/R10 valid sequence with wipe in the same cycle as the commit
        wr1(8'h70, 8'h01);
        chk(pulses == 0, "R8 arm alone no pulse", pulses, 0);
        wr1(8'h11, 8'h01);
        chk(pulses == 1, "R8 one pulse", pulses, 1);
        chk(wide_pulses == 0, "R8 single-clock pulse", wide_pulses, 0);
        chk(mmc_pwr_en == 1'b1, "R10 mmc back on", mmc_pwr_en, 1);
        chk(!cam0_pwr_en && !cam1_pwr_en, "R10 cams off", {cam1_pwr_en, cam0_pwr_en}, 0);
        exp_q.push_back(8'h00);
        rd_burst(8'h70, 1, "R10 reg 0x70 cleared");
        exp_q.push_back(8'h00); exp_q.push_back(8'h00);
        rd_burst(8'h11, 2, "R10 regs 0x11..0x12 cleared");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule